// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a byte-wide synchronous serial port. A 4-bit mode field selects whether it drives the serial clock as a master or follows an external clock as a slave. As a master it derives SCK from the system clock with one of three fixed divide ratios, or it advances SCK once per pulse of an external timer tick. As a slave it samples the SCK pin through a synchronizer. The slave can obey its active-low select pin or ignore it.

Software starts a transfer by writing a byte, which goes straight into the shift register. Each completed byte is captured into a single receive buffer, and a buffer-full status flags it until the buffer is read. A write-collision flag and a receive-overflow flag record misuse. Both flags are sticky and are cleared by dedicated strobes. The control fields (enable, clock polarity, mode) are plain inputs held by the surrounding register file.

Top module: `spi_port`

## Requirements
- R1: The mode values 0000, 0001 and 0010 (with `port_en`=1) make the port a master whose SCK half-period is 2, 8 or 32 `clk` cycles, that is, SCK runs at the clock rate divided by 4, 16 or 64.
- R2: Mode 0011 makes the port a master whose SCK changes level once per `tmr_tick` pulse, so one SCK period spans two ticks.
- R3: Whenever the master is not transferring, `sck_o` equals `cpol`: 0 gives an idle-low clock and 1 gives an idle-high clock.
- R4: Data moves MSB first over 8 bits. `sdo` changes on the SCK edge that leaves the idle level, and `sdi` is sampled on the edge that returns to it. After the eighth sample the received byte appears on `buf_rdata` and `buf_full` rises.
- R5: A one-cycle `buf_rd` pulse clears `buf_full`.
- R6: A `buf_wr` while `busy`=1 sets `wcol` and is discarded, so the byte in progress is unchanged. `wcol` stays 1 until a `clr_wcol` pulse.
- R7: In slave mode, a byte that completes while `buf_full`=1 sets `ovf`. The new byte is dropped and `buf_rdata` keeps the unread byte. `ovf` stays 1 until a `clr_ovf` pulse.
- R8: In master mode `ovf` never sets, and each completed byte replaces the buffer contents whether or not the buffer was read.
- R9: In mode 0100, `sdo_oe` is 1 only while `ss_n_i`=0. Raising `ss_n_i` in the middle of a byte cancels it: `busy` falls, and the next byte is counted from its first bit.
- R10: In mode 0101, `ss_n_i` is ignored: a byte is received and `sdo_oe`=1 while `ss_n_i`=1.
- R11: With `port_en`=0, or with a mode value other than 0000 to 0101, the port is idle: `busy`, `sck_oe` and `sdo_oe` are 0, and `buf_wr` starts nothing and sets no flag.
- R12: In slave mode `sck_oe`=0. A byte written while the slave is not busy is shifted out MSB first on `sdo` during the next byte from the external master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; 0 holds the port idle |
| cpol | input | 1 | SCK idle level |
| mode | input | 4 | Mode select field |
| tmr_tick | input | 1 | Timer pulse that clocks mode 0011 |
| buf_wr | input | 1 | Write strobe for the transmit byte |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Read strobe; clears buffer-full |
| buf_rdata | output | 8 | Receive buffer contents |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| busy | output | 1 | A byte is in progress |
| buf_full | output | 1 | The receive buffer holds an unread byte |
| wcol | output | 1 | Sticky write-collision flag |
| ovf | output | 1 | Sticky receive-overflow flag |
| sck_i | input | 1 | SCK pin input (slave) |
| sck_o | output | 1 | SCK pin output (master) |
| sck_oe | output | 1 | SCK output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The assertions assume that `mode`, `cpol` and `port_en` change only while no byte is in progress. They also assume that an external SCK half-period spans well over the synchronizer depth, and that the remote side changes `sdi` only on the leaving-idle edge. The stimulus follows all three. The bench reprograms the port only between transfers. It drives the slave clock with eight-cycle half-periods. For master transfers it uses a remote model that updates `sdi` only when `sck_o` leaves its idle level. When polarity changes in slave mode, the bench first deselects the port and moves SCK to the new idle level, so no spurious edge reaches the synchronizer.

// File: rtl/spi_port_pkg.sv
// Package spi_port_pkg
// Shared types and the mode decoder for the SPI port.
// Assumes a 4-bit mode field. Codes 00xx are master, 0100 and 0101 are slave,
// and every other code is treated as idle.
package spi_port_pkg;

    typedef enum logic [1:0] {
        ROLE_OFF    = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } role_e;

    localparam logic [3:0] MODE_SLV_SEL  = 4'b0100;
    localparam logic [3:0] MODE_SLV_FREE = 4'b0101;

    // Maps the enable bit and the mode field to the operating role.
    function automatic role_e decode_role(input logic en, input logic [3:0] md);
        if (!en)                                       return ROLE_OFF;
        if (md[3:2] == 2'b00)                          return ROLE_MASTER;
        if (md == MODE_SLV_SEL || md == MODE_SLV_FREE) return ROLE_SLAVE;
        return ROLE_OFF;
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
// Module spi_sck_gen
// Master serial-clock generator. While run is high it counts half-periods and
// toggles a phase bit. Each toggle comes with a one-cycle lead or trail pulse
// that is valid in the cycle before the SCK output changes.
// Assumes DIV_A, DIV_B and DIV_C are even and at least 2. sel = 3 selects the
// external tick, which advances one half-period per pulse.
module spi_sck_gen #(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       cpol,
    input  logic [1:0] sel,
    input  logic       tmr_tick,
    output logic       sck,
    output logic       lead,
    output logic       trail
);
    localparam int HALF_A   = DIV_A / 2;
    localparam int HALF_B   = DIV_B / 2;
    localparam int HALF_C   = DIV_C / 2;
    localparam int HALF_AB  = (HALF_A > HALF_B) ? HALF_A : HALF_B;
    localparam int HALF_MAX = (HALF_AB > HALF_C) ? HALF_AB : HALF_C;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_lim;
    logic             step;
    logic             phase;
    logic             at_edge;

    // Choose the half-period length and the count enable for the selected source.
    always_comb begin
        step = 1'b1;
        case (sel)
            2'd0:    half_lim = CNT_W'(HALF_A);
            2'd1:    half_lim = CNT_W'(HALF_B);
            2'd2:    half_lim = CNT_W'(HALF_C);
            default: begin
                half_lim = CNT_W'(1);
                step     = tmr_tick;
            end
        endcase
    end

    assign at_edge = run && step && (cnt == half_lim - 1'b1);
    assign lead    = at_edge && !phase;
    assign trail   = at_edge && phase;
    assign sck     = cpol ^ phase;

    // Half-period counter and phase toggle; both rest at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (!run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (step) begin
            if (cnt == half_lim - 1'b1) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_slave_front.sv
// Module spi_slave_front
// Slave input front end. It synchronizes SCK, data-in and select to clk and
// turns SCK transitions into lead and trail pulses relative to the idle level.
// Assumes the external SCK half-period is several clk cycles longer than
// SYNC_STAGES, and that SYNC_STAGES is at least 2.
module spi_slave_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on,
    input  logic cpol,
    input  logic ss_use,
    input  logic sck_i,
    input  logic sdi,
    input  logic ss_n_i,
    output logic selected,
    output logic sdi_s,
    output logic lead,
    output logic trail
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sck_q;
    logic [TOP:0] sdi_q;
    logic [TOP:0] ss_q;
    logic         sck_prev;
    logic         sck_s;
    logic         toggled;

    // Synchronizer chains, plus one extra stage of SCK history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= '0;
            sdi_q    <= '0;
            ss_q     <= '1;
            sck_prev <= 1'b0;
        end else begin
            sck_q    <= {sck_q[TOP-1:0], sck_i};
            sdi_q    <= {sdi_q[TOP-1:0], sdi};
            ss_q     <= {ss_q[TOP-1:0], ss_n_i};
            sck_prev <= sck_q[TOP];
        end
    end

    assign sck_s    = sck_q[TOP];
    assign sdi_s    = sdi_q[TOP];
    assign selected = !ss_use || !ss_q[TOP];
    assign toggled  = sck_s ^ sck_prev;
    assign lead     = on && selected && toggled && (sck_prev == cpol);
    assign trail    = on && selected && toggled && (sck_s == cpol);

endmodule

// File: rtl/spi_shifter.sv
// Module spi_shifter
// Shared shift engine. A lead pulse drives the next MSB onto sdo. A trail
// pulse shifts sdi in at the LSB and counts the bit. fin flags the last bit,
// and rx_next is the complete byte in that cycle.
// Assumes load arrives only while no byte is active, and that lead and trail
// pulses alternate.
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         lead,
    input  logic         trail,
    input  logic         sdi,
    output logic         sdo,
    output logic         active,
    output logic         fin,
    output logic [W-1:0] rx_next
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    assign fin     = trail && (cnt == CW'(W - 1));
    assign rx_next = {sh[W-2:0], sdi};

    // Shift register, bit counter, data-out latch and activity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            sdo    <= 1'b0;
            active <= 1'b0;
        end else if (clear) begin
            cnt    <= '0;
            active <= 1'b0;
        end else begin
            if (load) begin
                sh <= load_val;
            end
            if (lead) begin
                sdo    <= load ? load_val[W-1] : sh[W-1];
                active <= 1'b1;
            end
            if (trail) begin
                sh  <= rx_next;
                cnt <= fin ? '0 : cnt + 1'b1;
                if (fin) begin
                    active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/spi_port.sv
// Module spi_port
// Top level of the configurable SPI port. It decodes the role, routes edge
// pulses from either the master clock generator or the slave front end into
// one shifter, and owns the receive buffer and the sticky flags.
// Assumes mode, cpol and port_en change only while no byte is in progress.
module spi_port #(
    parameter int DATA_W      = 8,
    parameter int DIV_A       = 4,
    parameter int DIV_B       = 16,
    parameter int DIV_C       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              cpol,
    input  logic [3:0]        mode,
    input  logic              tmr_tick,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic              clr_wcol,
    input  logic              clr_ovf,
    output logic              busy,
    output logic              buf_full,
    output logic              wcol,
    output logic              ovf,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              ss_n_i
);
    import spi_port_pkg::*;

    role_e             role;
    logic              is_m;
    logic              is_s;
    logic              m_run;
    logic              gen_sck, gen_lead, gen_trail;
    logic              fe_sel, fe_sdi, fe_lead, fe_trail;
    logic              lead, trail, sdi_mux;
    logic              sh_active, sh_fin, sh_clear;
    logic              wr_ok, wr_hit;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] rx_buf;

    assign role = decode_role(port_en, mode);
    assign is_m = (role == ROLE_MASTER);
    assign is_s = (role == ROLE_SLAVE);

    spi_sck_gen #(
        .DIV_A(DIV_A),
        .DIV_B(DIV_B),
        .DIV_C(DIV_C)
    ) sck_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (m_run),
        .cpol     (cpol),
        .sel      (mode[1:0]),
        .tmr_tick (tmr_tick),
        .sck      (gen_sck),
        .lead     (gen_lead),
        .trail    (gen_trail)
    );

    spi_slave_front #(
        .SYNC_STAGES(SYNC_STAGES)
    ) front_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .on       (is_s),
        .cpol     (cpol),
        .ss_use   (mode == MODE_SLV_SEL),
        .sck_i    (sck_i),
        .sdi      (sdi),
        .ss_n_i   (ss_n_i),
        .selected (fe_sel),
        .sdi_s    (fe_sdi),
        .lead     (fe_lead),
        .trail    (fe_trail)
    );

    assign lead     = is_m ? gen_lead  : fe_lead;
    assign trail    = is_m ? gen_trail : fe_trail;
    assign sdi_mux  = is_m ? sdi       : fe_sdi;
    assign sh_clear = (role == ROLE_OFF) || (is_s && !fe_sel);

    assign busy   = is_m ? m_run : (is_s ? sh_active : 1'b0);
    assign wr_ok  = (is_m || is_s) && buf_wr && !busy;
    assign wr_hit = (is_m || is_s) && buf_wr && busy;

    spi_shifter #(
        .W(DATA_W)
    ) shifter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clear),
        .load     (wr_ok),
        .load_val (buf_wdata),
        .lead     (lead),
        .trail    (trail),
        .sdi      (sdi_mux),
        .sdo      (sdo),
        .active   (sh_active),
        .fin      (sh_fin),
        .rx_next  (rx_next)
    );

    // Master run flag: set by an accepted write, dropped when the last bit is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 1'b0;
        end else if (!is_m || sh_fin) begin
            m_run <= 1'b0;
        end else if (wr_ok) begin
            m_run <= 1'b1;
        end
    end

    // Receive buffer and full flag; a slave keeps the unread byte when one is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf   <= '0;
            buf_full <= 1'b0;
        end else if (sh_fin && (is_m || !buf_full || buf_rd)) begin
            rx_buf   <= rx_next;
            buf_full <= 1'b1;
        end else if (buf_rd) begin
            buf_full <= 1'b0;
        end
    end

    // Sticky overflow flag, set only by a slave completion that finds the buffer full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (sh_fin && is_s && buf_full && !buf_rd) begin
            ovf <= 1'b1;
        end else if (clr_ovf) begin
            ovf <= 1'b0;
        end
    end

    // Sticky write-collision flag, set by a write that arrives mid-byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcol <= 1'b0;
        end else if (wr_hit) begin
            wcol <= 1'b1;
        end else if (clr_wcol) begin
            wcol <= 1'b0;
        end
    end

    assign buf_rdata = rx_buf;
    assign sck_o     = is_m ? gen_sck : cpol;
    assign sck_oe    = is_m;
    assign sdo_oe    = is_m || (is_s && fe_sel);

endmodule

// File: rtl/spi_port_chk.sv
// Module spi_port_chk
// Checker bound to spi_port. It watches port-level relations between the
// status flags, the clock output and the control strobes.
// Assumes control fields change only while the port is not busy.
module spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic cpol,
    input logic buf_wr,
    input logic buf_rd,
    input logic clr_wcol,
    input logic clr_ovf,
    input logic busy,
    input logic buf_full,
    input logic wcol,
    input logic ovf,
    input logic sck_o,
    input logic sck_oe,
    input logic sdo_oe
);
    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !busy) |-> (sck_o == cpol));

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !busy) |=> !buf_full);

    p_wcol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && busy) |=> wcol);

    p_wcol_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !clr_wcol) |=> wcol);

    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !ovf) |=> !ovf);

    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (!sck_oe && !sdo_oe && !busy));

endmodule

bind spi_port spi_port_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .cpol     (cpol),
    .buf_wr   (buf_wr),
    .buf_rd   (buf_rd),
    .clr_wcol (clr_wcol),
    .clr_ovf  (clr_ovf),
    .busy     (busy),
    .buf_full (buf_full),
    .wcol     (wcol),
    .ovf      (ovf),
    .sck_o    (sck_o),
    .sck_oe   (sck_oe),
    .sdo_oe   (sdo_oe)
);

// File: tb/spi_port_tb_top.sv
`timescale 1ns/1ps
// Testbench for spi_port. It walks a table of master transfers and then runs
// directed tests for reset, flags, idle modes and the slave modes.
module spi_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, port_en, cpol, tmr_tick;
    logic [3:0] mode;
    logic       buf_wr, buf_rd, clr_wcol, clr_ovf;
    logic [7:0] buf_wdata, buf_rdata;
    logic       busy, buf_full, wcol, ovf;
    logic       sck_o, sck_oe, sdo, sdo_oe;
    logic       sck_drv, ss_n, sdi_drv, sdi_model, model_on, sdi_w;

    always #4 clk = ~clk;

    assign sdi_w = model_on ? sdi_model : sdi_drv;

    spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .cpol(cpol), .mode(mode),
        .tmr_tick(tmr_tick), .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
        .buf_rdata(buf_rdata), .clr_wcol(clr_wcol), .clr_ovf(clr_ovf), .busy(busy),
        .buf_full(buf_full), .wcol(wcol), .ovf(ovf), .sck_i(sck_drv), .sck_o(sck_o),
        .sck_oe(sck_oe), .sdi(sdi_w), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n_i(ss_n)
    );

    typedef struct packed {
        logic [3:0] md;
        logic       pol;
        logic [7:0] tx;
        logic [7:0] rx;
        logic [7:0] half;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{4'h0, 1'b0, 8'hA5, 8'h3C, 8'd2},
        '{4'h0, 1'b1, 8'h5A, 8'hC3, 8'd2},
        '{4'h1, 1'b0, 8'h81, 8'h7E, 8'd8},
        '{4'h2, 1'b1, 8'hF0, 8'h0F, 8'd32},
        '{4'h3, 1'b0, 8'h69, 8'h96, 8'd3},
        '{4'h3, 1'b1, 8'h12, 8'hED, 8'd3}
    };

    int         checks = 0;
    int         errors = 0;
    logic [7:0] rem, mosi_cap, got;
    time        last_t = 0;
    int         half_cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Timer tick: one-cycle pulse every third clock.
    initial begin
        tmr_tick = 1'b0;
        forever begin
            repeat (2) @(negedge clk);
            tmr_tick = 1'b1;
            @(negedge clk);
            tmr_tick = 1'b0;
        end
    end

    // Remote slave model for master transfers: measures half-periods, changes
    // sdi on the leaving-idle edge and captures sdo on the return edge.
    initial begin
        sdi_model = 1'b0;
        forever begin
            @(sck_o);
            if (model_on) begin
                half_cyc = int'(($time - last_t) / 8);
                last_t   = $time;
                if (sck_o !== cpol) begin
                    sdi_model = rem[7];
                    rem       = {rem[6:0], 1'b0};
                end else begin
                    mosi_cap = {mosi_cap[6:0], sdo};
                end
            end
        end
    end

    task automatic write_buf(input logic [7:0] d);
        @(negedge clk);
        buf_wdata = d;
        buf_wr    = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic read_buf();
        @(negedge clk);
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
    endtask

    task automatic pulse_clr(input logic which_ovf);
        @(negedge clk);
        if (which_ovf) clr_ovf = 1'b1; else clr_wcol = 1'b1;
        @(negedge clk);
        clr_ovf  = 1'b0;
        clr_wcol = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Acts as an external master: eight-cycle half-periods, MSB first.
    task automatic slave_shift(input logic [7:0] b, input int nbits, output logic [7:0] miso);
        miso = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sck_drv = ~cpol;
            sdi_drv = b[7-i];
            repeat (8) @(negedge clk);
            miso    = {miso[6:0], sdo};
            sck_drv = cpol;
            repeat (8) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; port_en = 1'b0; cpol = 1'b0; mode = 4'h0;
        buf_wr = 1'b0; buf_wdata = '0; buf_rd = 1'b0; clr_wcol = 1'b0; clr_ovf = 1'b0;
        sck_drv = 1'b0; ss_n = 1'b1; sdi_drv = 1'b0; model_on = 1'b0;
        rem = '0; mosi_cap = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R11)
        chk("R11 reset busy", busy, 0);
        chk("R11 reset buf_full", buf_full, 0);
        chk("R11 reset wcol", wcol, 0);
        chk("R11 reset ovf", ovf, 0);
        chk("R11 reset sck_oe", sck_oe, 0);
        chk("R11 reset sdo_oe", sdo_oe, 0);

        // Table of master transfers (R1, R2, R3, R4, R5, R8)
        port_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            string t;
            t        = (VEC[v].md == 4'h3) ? "R2 tick half-period" : "R1 divided half-period";
            model_on = 1'b0;
            mode     = VEC[v].md;
            cpol     = VEC[v].pol;
            repeat (3) @(negedge clk);
            chk("R3 idle level before", sck_o, cpol);
            rem = VEC[v].rx; mosi_cap = '0; last_t = $time; model_on = 1'b1;
            write_buf(VEC[v].tx);
            wait_idle();
            chk("R4 received byte", buf_rdata, VEC[v].rx);
            chk("R4 transmitted byte", mosi_cap, VEC[v].tx);
            chk(t, half_cyc, VEC[v].half);
            chk("R3 idle level after", sck_o, cpol);
            chk("R4 buf_full set", buf_full, 1);
            read_buf();
            chk("R5 read clears full", buf_full, 0);
            chk("R8 master no overflow", ovf, 0);
        end

        // Write collision in master mode (R6)
        model_on = 1'b0; mode = 4'h1; cpol = 1'b0;
        repeat (3) @(negedge clk);
        rem = 8'h55; mosi_cap = '0; last_t = $time; model_on = 1'b1;
        write_buf(8'hC3);
        repeat (5) @(negedge clk);
        write_buf(8'h11);
        chk("R6 wcol set", wcol, 1);
        wait_idle();
        chk("R6 colliding write discarded", mosi_cap, 8'hC3);
        chk("R4 byte after collision", buf_rdata, 8'h55);
        repeat (3) @(negedge clk);
        chk("R6 wcol sticky", wcol, 1);
        pulse_clr(1'b0);
        chk("R6 wcol cleared", wcol, 0);

        // Master overwrite of an unread buffer (R8)
        model_on = 1'b0; mode = 4'h0;
        repeat (3) @(negedge clk);
        rem = 8'h99; mosi_cap = '0; last_t = $time; model_on = 1'b1;
        write_buf(8'h22);
        wait_idle();
        chk("R8 ovf stays low", ovf, 0);
        chk("R8 buffer overwritten", buf_rdata, 8'h99);
        chk("R8 buf_full", buf_full, 1);
        read_buf();

        // Disabled port (R11)
        model_on = 1'b0; port_en = 1'b0;
        write_buf(8'hAA);
        repeat (10) @(negedge clk);
        chk("R11 disabled busy", busy, 0);
        chk("R11 disabled sck_oe", sck_oe, 0);
        chk("R11 disabled sdo_oe", sdo_oe, 0);
        chk("R11 disabled no wcol", wcol, 0);

        // Unused mode code (R11)
        port_en = 1'b1; mode = 4'b1000;
        write_buf(8'hAA);
        repeat (10) @(negedge clk);
        chk("R11 unused mode busy", busy, 0);
        chk("R11 unused mode sck_oe", sck_oe, 0);
        chk("R11 unused mode buf_full", buf_full, 0);

        // Slave with select enforced (R9, R12, R4)
        mode = 4'b0100; cpol = 1'b0; ss_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 sdo_oe off while deselected", sdo_oe, 0);
        chk("R12 slave sck_oe", sck_oe, 0);
        ss_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 sdo_oe on while selected", sdo_oe, 1);
        write_buf(8'hB7);
        slave_shift(8'h4E, 8, got);
        chk("R12 slave transmit", got, 8'hB7);
        chk("R4 slave receive", buf_rdata, 8'h4E);
        chk("R4 slave buf_full", buf_full, 1);

        // Slave overflow (R7)
        slave_shift(8'h13, 8, got);
        chk("R7 ovf set", ovf, 1);
        chk("R7 old byte kept", buf_rdata, 8'h4E);
        repeat (5) @(negedge clk);
        chk("R7 ovf sticky", ovf, 1);
        pulse_clr(1'b1);
        chk("R7 ovf cleared", ovf, 0);
        read_buf();
        chk("R5 slave read clears full", buf_full, 0);

        // Deselect mid-byte with idle-high clock (R9, R6)
        ss_n = 1'b1;
        repeat (5) @(negedge clk);
        sck_drv = 1'b1; cpol = 1'b1;
        repeat (5) @(negedge clk);
        ss_n = 1'b0;
        repeat (5) @(negedge clk);
        slave_shift(8'hFF, 3, got);
        chk("R9 busy mid-byte", busy, 1);
        write_buf(8'h5A);
        chk("R6 slave wcol", wcol, 1);
        pulse_clr(1'b0);
        ss_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 sdo_oe off after deselect", sdo_oe, 0);
        chk("R9 byte cancelled", busy, 0);
        ss_n = 1'b0;
        repeat (5) @(negedge clk);
        slave_shift(8'h6D, 8, got);
        chk("R9 count restarted", buf_rdata, 8'h6D);
        chk("R9 buf_full after restart", buf_full, 1);
        read_buf();

        // Slave with select ignored (R10, R12)
        mode = 4'b0101; ss_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 sdo_oe while ss high", sdo_oe, 1);
        write_buf(8'h3C);
        slave_shift(8'hA9, 8, got);
        chk("R10 receive with ss high", buf_rdata, 8'hA9);
        chk("R10 buf_full", buf_full, 1);
        chk("R12 transmit idle-high", got, 8'h3C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule